// File: doc/BRIEF.md
# Write-Enable and Sector Protection Controller

This block keeps the write-permission state of a serial flash front end: a one-bit write-enable latch, a lock bit that freezes the protection settings, and one protection bit for each 64 KB sector. A command decoder ahead of it sends one record per completed chip-select frame. Each record carries the command kind, the 24-bit address, and three qualifiers: all three address bytes arrived, the frame ended on a byte boundary, and at least one data byte arrived. The record also holds the status byte for a status write. The block updates its state from each record. For program, block-erase and chip-erase records it also returns a one-cycle verdict that says whether the array operation may start.

Records arrive on a valid/ready stream. `cmd_ready` is low during reset and from the first clock after reset it stays high, so a record is taken on every clock edge where `cmd_valid` is high. The verdict stream (`res_valid`, `res_go`) cannot be stalled. It is a registered pulse one cycle after the record is taken, and the consumer must capture it in that cycle. `rd_sector`/`rd_prot` is a combinational read port that shows the protection bit of any sector. The write-protect pin `wp_n` only qualifies status-register writes.

Top module: `wprot_ctrl`

## Requirements
- R1: After reset `wel`=0, `sprl`=0, `res_valid`=0, every sector reads protected (`rd_prot`=1), and `cmd_ready` is 1 from the first clock after reset is released.
- R2: Command kind 1 (enable) sets `wel` and kind 2 (disable) clears it, but only when `cmd_byte_ok`=1. Otherwise `wel` keeps its value.
- R3: Kind 3 (protect) sets the bit of sector `cmd_addr[21:16]` and kind 4 (unprotect) clears it. This happens only when `wel`=1, `sprl`=0, `cmd_addr_ok`=1 and `cmd_byte_ok`=1. No other sector's bit changes.
- R4: Kinds 3, 4, 5, 6 and 7 leave `wel`=0 after they are taken, whether or not they succeed.
- R5: A protect or unprotect record with `cmd_addr_ok`=0 or `cmd_byte_ok`=0 leaves the protection bits unchanged.
- R6: While `sprl`=1, protect and unprotect records leave the protection bits unchanged.
- R7: Kind 5 (status write) is accepted when `wel`=1, `cmd_byte_ok`=1 and `cmd_data_ok`=1. If `sprl`=0 and `wp_n`=1, a value of 1111 in status bits [5:2] protects all sectors and 0000 unprotects all sectors. Any other pattern in those bits changes no sector.
- R8: An accepted status write with `wp_n`=1 loads `sprl` from status bit 7. With `wp_n`=0 it can set `sprl` but cannot clear it.
- R9: Kind 6 (program or block erase) produces `res_valid`=1 one cycle after it is taken. `res_go`=1 only if `wel`=1, all three qualifiers are 1, and the addressed sector is unprotected.
- R10: Kind 7 (chip erase) produces `res_valid`=1 one cycle later. `res_go`=1 only if `wel`=1, `cmd_byte_ok`=1 and no sector is protected.
- R11: Address bits 23:22 play no part in choosing the sector.
- R12: Kind 0 changes no state and produces no verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command record present |
| cmd_ready | output | 1 | Record accepted on this edge when high |
| cmd_kind | input | 3 | 0 none, 1 enable, 2 disable, 3 protect, 4 unprotect, 5 status write, 6 program/block erase, 7 chip erase |
| cmd_addr | input | 24 | Byte address from the frame |
| cmd_addr_ok | input | 1 | All three address bytes received |
| cmd_byte_ok | input | 1 | Frame ended on a byte boundary |
| cmd_data_ok | input | 1 | At least one data byte received |
| cmd_sr | input | 8 | Status byte for a status write |
| wp_n | input | 1 | Write-protect pin, low = hardware lock |
| wel | output | 1 | Write-enable latch |
| sprl | output | 1 | Protection lock bit |
| res_valid | output | 1 | Verdict pulse for kinds 6 and 7 |
| res_go | output | 1 | Array operation may start |
| rd_sector | input | 6 | Sector index to read |
| rd_prot | output | 1 | Protection bit of `rd_sector` |

## Verification
Two functions can act on the same clock edge. One is the verdict for a program record, which reads `wel` and the sector bit. The other is the `wel` clear that the same record causes. The bench raises `wel`, then sends a program or chip-erase record. It checks that the verdict still reflects the old `wel`=1, while `wel` reads 0 in the same sampling cycle. A status write that sets `sprl` and protects all sectors also provokes a same-edge conflict. The global action must be decided by the old `sprl`=0, and the bench judges this from the sector bit read afterwards.

// File: rtl/wprot_pkg.sv
package wprot_pkg;
  typedef enum logic [2:0] {
    K_NONE   = 3'd0,
    K_WREN   = 3'd1,
    K_WRDI   = 3'd2,
    K_PROT   = 3'd3,
    K_UNPROT = 3'd4,
    K_WRSR   = 3'd5,
    K_PEOP   = 3'd6,
    K_CHIP   = 3'd7
  } cmd_kind_e;
endpackage

// File: rtl/wprot_wel.sv
module wprot_wel (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic wel_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)      wel_o <= 1'b0;
    else if (clr_i)  wel_o <= 1'b0;
    else if (set_i)  wel_o <= 1'b1;
  end
endmodule

// File: rtl/wprot_lock.sv
module wprot_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_i,
  input  logic val_i,
  output logic lock_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     lock_o <= 1'b0;
    else if (wr_i)  lock_o <= val_i;
  end
endmodule

// File: rtl/wprot_sectors.sv
module wprot_sectors #(
  parameter int NSEC  = 64,
  parameter int IDX_W = $clog2(NSEC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_one_i,
  input  logic             clr_one_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             set_all_i,
  input  logic             clr_all_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_bit_o,
  output logic             op_bit_o,
  output logic             any_o,
  output logic [NSEC-1:0]  bits_o
);
  for (genvar s = 0; s < NSEC; s++) begin : g_sec
    logic hit;
    assign hit = (idx_i == IDX_W'(s));
    always_ff @(posedge clk) begin
      if (!rst_n)                  bits_o[s] <= 1'b1;
      else if (set_all_i)          bits_o[s] <= 1'b1;
      else if (clr_all_i)          bits_o[s] <= 1'b0;
      else if (hit && set_one_i)   bits_o[s] <= 1'b1;
      else if (hit && clr_one_i)   bits_o[s] <= 1'b0;
    end
  end

  assign rd_bit_o = bits_o[rd_idx_i];
  assign op_bit_o = bits_o[idx_i];
  assign any_o    = |bits_o;
endmodule

// File: rtl/wprot_ctrl.sv
module wprot_ctrl #(
  parameter int ADDR_W   = 24,
  parameter int NSEC     = 64,
  parameter int SEC_LSB  = 16,
  parameter int SR_W     = 8,
  parameter int LOCK_BIT = 7,
  parameter int GLOB_HI  = 5,
  parameter int GLOB_LO  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  output logic                     cmd_ready,
  input  logic [2:0]               cmd_kind,
  input  logic [ADDR_W-1:0]        cmd_addr,
  input  logic                     cmd_addr_ok,
  input  logic                     cmd_byte_ok,
  input  logic                     cmd_data_ok,
  input  logic [SR_W-1:0]          cmd_sr,
  input  logic                     wp_n,
  output logic                     wel,
  output logic                     sprl,
  output logic                     res_valid,
  output logic                     res_go,
  input  logic [$clog2(NSEC)-1:0]  rd_sector,
  output logic                     rd_prot
);
  import wprot_pkg::*;

  localparam int IDX_W  = $clog2(NSEC);
  localparam int GLOB_W = GLOB_HI - GLOB_LO + 1;

  cmd_kind_e        kind;
  logic             acc, gated, prot_ok, sr_ok, glob_ok, go_now;
  logic [IDX_W-1:0] sec;
  logic             op_bit, any_prot, lock_val;
  logic [NSEC-1:0]  prot_bits;

  always_ff @(posedge clk) begin
    if (!rst_n) cmd_ready <= 1'b0;
    else        cmd_ready <= 1'b1;
  end

  assign kind  = cmd_kind_e'(cmd_kind);
  assign acc   = cmd_valid && cmd_ready;
  assign sec   = cmd_addr[SEC_LSB +: IDX_W];
  assign gated = (kind == K_PROT) || (kind == K_UNPROT) || (kind == K_WRSR) ||
                 (kind == K_PEOP) || (kind == K_CHIP);

  assign prot_ok = acc && wel && !sprl && cmd_addr_ok && cmd_byte_ok;
  assign sr_ok   = acc && (kind == K_WRSR) && wel && cmd_byte_ok && cmd_data_ok;
  assign glob_ok = sr_ok && !sprl && wp_n;
  assign lock_val = wp_n ? cmd_sr[LOCK_BIT] : (sprl || cmd_sr[LOCK_BIT]);

  assign go_now = acc && wel && cmd_byte_ok &&
                  (((kind == K_PEOP) && cmd_addr_ok && cmd_data_ok && !op_bit) ||
                   ((kind == K_CHIP) && !any_prot));

  wprot_wel u_wel (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (acc && (kind == K_WREN) && cmd_byte_ok),
    .clr_i (acc && (((kind == K_WRDI) && cmd_byte_ok) || gated)),
    .wel_o (wel)
  );

  wprot_lock u_lock (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_i   (sr_ok),
    .val_i  (lock_val),
    .lock_o (sprl)
  );

  wprot_sectors #(.NSEC(NSEC), .IDX_W(IDX_W)) u_sec (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_one_i (prot_ok && (kind == K_PROT)),
    .clr_one_i (prot_ok && (kind == K_UNPROT)),
    .idx_i     (sec),
    .set_all_i (glob_ok && (cmd_sr[GLOB_HI:GLOB_LO] == {GLOB_W{1'b1}})),
    .clr_all_i (glob_ok && (cmd_sr[GLOB_HI:GLOB_LO] == {GLOB_W{1'b0}})),
    .rd_idx_i  (rd_sector),
    .rd_bit_o  (rd_prot),
    .op_bit_o  (op_bit),
    .any_o     (any_prot),
    .bits_o    (prot_bits)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_go    <= 1'b0;
    end else begin
      res_valid <= acc && ((kind == K_PEOP) || (kind == K_CHIP));
      res_go    <= go_now;
    end
  end

  // R2: the latch only rises after a complete enable record
  a_r2_wel_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> $past(acc && (kind == K_WREN) && cmd_byte_ok));

  // R4: gated commands leave the latch clear
  a_r4_wel_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && gated) |=> !wel);

  // R6: locked protection bits do not move on sector commands
  a_r6_lock_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && sprl && ((kind == K_PROT) || (kind == K_UNPROT))) |=> $stable(prot_bits));

  // R9: a go verdict needs a set latch in the cycle of acceptance
  a_r9_go_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
    res_go |-> ($past(wel) && res_valid));

  // R10: chip erase goes only on an all-unprotected array
  a_r10_chip_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (res_go && $past(kind == K_CHIP)) |-> $past(!any_prot));

  // R3: protection bits change only with the latch set or by a status write
  a_r3_bits_need_wel: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(prot_bits) |-> $past(wel));
endmodule

// File: tb/sim_wprot_ctrl.sv
module sim_wprot_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_kind = 3'd0;
  logic [23:0] cmd_addr = 24'd0;
  logic        cmd_addr_ok = 1'b0, cmd_byte_ok = 1'b0, cmd_data_ok = 1'b0;
  logic [7:0]  cmd_sr = 8'd0;
  logic        wp_n = 1'b1;
  logic        wel, sprl, res_valid, res_go, rd_prot;
  logic [5:0]  rd_sector = 6'd0;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wprot_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_kind(cmd_kind), .cmd_addr(cmd_addr), .cmd_addr_ok(cmd_addr_ok),
    .cmd_byte_ok(cmd_byte_ok), .cmd_data_ok(cmd_data_ok), .cmd_sr(cmd_sr),
    .wp_n(wp_n), .wel(wel), .sprl(sprl), .res_valid(res_valid), .res_go(res_go),
    .rd_sector(rd_sector), .rd_prot(rd_prot)
  );

  // {req[3:0], kind[2:0], sector[5:0], {addr_ok,byte_ok,data_ok}, sr[7:0], wp_n,
  //  expected {wel, sprl, res_valid, res_go, rd_prot}}
  localparam int NV = 37;
  localparam logic [29:0] VEC [NV] = '{
    {4'd4,  3'd4, 6'd5,  3'b111, 8'h00, 1'b1, 5'b00001}, // R4 unprotect without latch
    {4'd2,  3'd1, 6'd5,  3'b101, 8'h00, 1'b1, 5'b00001}, // R2 enable off byte boundary
    {4'd2,  3'd1, 6'd5,  3'b111, 8'h00, 1'b1, 5'b10001}, // R2 enable
    {4'd5,  3'd4, 6'd5,  3'b011, 8'h00, 1'b1, 5'b00001}, // R5 short address
    {4'd2,  3'd1, 6'd5,  3'b111, 8'h00, 1'b1, 5'b10001},
    {4'd3,  3'd4, 6'd5,  3'b111, 8'h00, 1'b1, 5'b00000}, // R3 unprotect sector 5
    {4'd9,  3'd6, 6'd5,  3'b111, 8'h00, 1'b1, 5'b00100}, // R9 no latch -> refuse
    {4'd2,  3'd1, 6'd5,  3'b111, 8'h00, 1'b1, 5'b10000},
    {4'd9,  3'd6, 6'd5,  3'b111, 8'h00, 1'b1, 5'b00110}, // R9 go, latch cleared same edge
    {4'd2,  3'd1, 6'd6,  3'b111, 8'h00, 1'b1, 5'b10001},
    {4'd9,  3'd6, 6'd6,  3'b111, 8'h00, 1'b1, 5'b00101}, // R9 protected sector
    {4'd2,  3'd1, 6'd6,  3'b111, 8'h00, 1'b1, 5'b10001},
    {4'd10, 3'd7, 6'd6,  3'b011, 8'h00, 1'b1, 5'b00101}, // R10 refused, sectors protected
    {4'd2,  3'd1, 6'd6,  3'b111, 8'h00, 1'b1, 5'b10001},
    {4'd2,  3'd2, 6'd6,  3'b101, 8'h00, 1'b1, 5'b10001}, // R2 disable off boundary
    {4'd2,  3'd2, 6'd6,  3'b111, 8'h00, 1'b1, 5'b00001}, // R2 disable
    {4'd2,  3'd1, 6'd40, 3'b111, 8'h00, 1'b1, 5'b10001},
    {4'd7,  3'd5, 6'd40, 3'b111, 8'h00, 1'b1, 5'b00000}, // R7 global unprotect
    {4'd2,  3'd1, 6'd40, 3'b111, 8'h00, 1'b1, 5'b10000},
    {4'd10, 3'd7, 6'd40, 3'b011, 8'h00, 1'b1, 5'b00110}, // R10 chip erase go
    {4'd2,  3'd1, 6'd9,  3'b111, 8'h00, 1'b1, 5'b10000},
    {4'd7,  3'd5, 6'd9,  3'b111, 8'hBC, 1'b1, 5'b01001}, // R7 global protect + lock
    {4'd2,  3'd1, 6'd9,  3'b111, 8'h00, 1'b1, 5'b11001},
    {4'd6,  3'd4, 6'd9,  3'b111, 8'h00, 1'b1, 5'b01001}, // R6 locked unprotect ignored
    {4'd2,  3'd1, 6'd9,  3'b111, 8'h00, 1'b1, 5'b11001},
    {4'd8,  3'd5, 6'd9,  3'b111, 8'h00, 1'b0, 5'b01001}, // R8 pin low keeps lock
    {4'd2,  3'd1, 6'd9,  3'b111, 8'h00, 1'b1, 5'b11001},
    {4'd8,  3'd5, 6'd9,  3'b111, 8'h00, 1'b1, 5'b00001}, // R8 lock cleared, no global
    {4'd2,  3'd1, 6'd9,  3'b111, 8'h00, 1'b1, 5'b10001},
    {4'd6,  3'd4, 6'd9,  3'b111, 8'h00, 1'b1, 5'b00000}, // R6 unlocked unprotect works
    {4'd2,  3'd1, 6'd9,  3'b111, 8'h00, 1'b1, 5'b10000},
    {4'd7,  3'd5, 6'd9,  3'b111, 8'h14, 1'b1, 5'b00000}, // R7 mixed pattern, no change
    {4'd2,  3'd1, 6'd9,  3'b111, 8'h00, 1'b1, 5'b10000},
    {4'd12, 3'd0, 6'd9,  3'b111, 8'h00, 1'b1, 5'b10000}, // R12 kind 0 inert
    {4'd3,  3'd3, 6'd9,  3'b111, 8'h00, 1'b0, 5'b00001}, // R3 protect sector 9
    {4'd2,  3'd1, 6'd9,  3'b111, 8'h00, 1'b1, 5'b10001},
    {4'd7,  3'd5, 6'd9,  3'b110, 8'hBC, 1'b1, 5'b00001}  // R7 no data byte: not applied
  };

  task automatic send(input logic [2:0] k, input logic [23:0] a, input logic [2:0] fl,
                      input logic [7:0] sr, input logic wp);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_kind = k; cmd_addr = a;
    {cmd_addr_ok, cmd_byte_ok, cmd_data_ok} = fl;
    cmd_sr = sr; wp_n = wp;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_all_prot(input string req);
    int bad = 0;
    for (int s = 0; s < 64; s++) begin
      rd_sector = 6'(s);
      #1;
      if (rd_prot !== 1'b1) bad++;
    end
    check(req, bad, 0);
  endtask

  initial begin
    repeat (1000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R1 reset state
    check("R1", {cmd_ready, wel, sprl, res_valid}, 4'b1000);
    check_all_prot("R1");

    for (int i = 0; i < NV; i++) begin
      logic [29:0] v;
      logic [4:0]  got;
      v = VEC[i];
      rd_sector = v[22:17];
      send(v[25:23], {2'b11, v[22:17], 16'hA5C3}, v[16:14], v[13:6], v[5]);
      got = {wel, sprl, res_valid, res_go, rd_prot};
      check($sformatf("R%0d vec%0d", v[29:26], i), got, v[4:0]);
    end

    // R3: a single-sector change leaves neighbours alone (7 and 9 protected)
    send(3'd1, 24'h000000, 3'b111, 8'h00, 1'b1);
    rd_sector = 6'd8;
    send(3'd4, {2'b00, 6'd8, 16'h0000}, 3'b111, 8'h00, 1'b1);
    check("R3 target", rd_prot, 1'b0);
    rd_sector = 6'd7; #1;
    check("R3 neighbour below", rd_prot, 1'b1);
    rd_sector = 6'd9; #1;
    check("R3 neighbour above", rd_prot, 1'b1);

    // R11: top address bits differ, same sector 8 is hit
    send(3'd1, 24'h000000, 3'b111, 8'h00, 1'b1);
    rd_sector = 6'd8;
    send(3'd6, {2'b10, 6'd8, 16'hFFFF}, 3'b111, 8'h00, 1'b1);
    check("R11", {res_valid, res_go}, 2'b11);

    // R8: with pin low the lock may still be set
    send(3'd1, 24'h000000, 3'b111, 8'h00, 1'b1);
    send(3'd5, 24'h000000, 3'b111, 8'h80, 1'b0);
    check("R8 set with pin low", {sprl, wel}, 2'b10);

    // R1: reset in mid-run restores defaults
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R1 re-reset", {cmd_ready, wel, sprl, res_valid}, 4'b1000);
    check_all_prot("R1 re-reset");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule